// File: doc/BRIEF.md
# SD/MMC Command Issue Unit

This block issues one command at a time on the command line of an SD or MMC card. Software writes a 32-bit argument and then a command word whose top bit starts the transfer. The unit builds a 48-bit frame, serialises it one bit per card-clock strobe, and then, if the command word asks for one, listens for a short or long response. It checks the response and records the outcome in a small status register.

The card clock is not generated here. A one-cycle strobe `sd_tick` marks each card bit time: the unit changes its command output on a strobe edge and samples the incoming line on the same strobes. Strobes must be at least two system clocks apart. A command that is marked to wait for previous data is held back while the card's data line reports busy, unless the same word also marks it as an abort.

Top module: `sd_cmd_issue`

## Requirements
- R1: A started command is sent as 48 bits, MSB first, one bit per strobe: a 0, a 1, command index (command word bits [5:0]), the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, zero seed) of the first 40 bits, and a closing 1. `cmd_oe` is high only while the frame is being driven, and `cmd_out` idles at 1.
- R2: Command word bit 31 starts the command and reads back as 0 once the command is taken. All other bits read back as written. A command-word write is ignored while bit 31 is still set or a command is in flight.
- R3: With bit 13 set and bit 14 clear, the command is not taken while `dat_busy` is high. With bit 14 set, the busy line is not waited for. Status bit 9 mirrors `dat_busy`.
- R4: With bit 6 clear, no response is awaited, and status bit 2 (done) sets after the closing bit.
- R5: With bit 6 set and bit 7 clear, a 48-bit response is received, and its 32 bits following the index field are stored in response word 0.
- R6: With bits 6 and 7 set, a 136-bit response is received, and its last 128 bits are stored in response words 3..0, with word 3 holding the most significant part.
- R7: With bit 8 set, a CRC7 mismatch sets status bit 6. The CRC covers the first 40 bits of a short response, or the 120 bits after the 8-bit header of a long one. With bit 8 clear, a mismatch sets nothing.
- R8: A response whose final bit is 0 sets status bit 1 (response error).
- R9: If no start bit (0) is sampled on any of the first 64 strobes after the frame ends, status bits 8 and 2 set and the response words keep their values. A start bit on the 64th strobe is accepted.
- R10: Writing the status register clears each flag whose data bit is 1. A flag being set in the same cycle wins.
- R11: After reset all registers read 0, `cmd_out` is 1 and `cmd_oe` is 0.
- R12: Register map: argument at address 0, command word at 1, status at 2, response words 0..3 at 4..7. Other addresses read 0. Read data appears one clock after the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Registered read data |
| sd_tick | input | 1 | One-cycle card bit-time strobe |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from the card |
| dat_busy | input | 1 | Card data line reports busy |

## Verification
Embedded assertions check the following on every cycle:
- The command line changes only on strobes, and the enable drops together with the transmit-done pulse.
- A timeout never coincides with a received response, and it follows a strobe on which the line was still idle.
- The start bit is gone after a take, and no take happens while a waiting command sees busy.
- A CRC flag rises only for commands that asked for checking.

The bench scenarios are needed for the rest:
- frame content and CRC values;
- where the response bits land in the four words;
- the exact 64-strobe timeout boundary;
- that writes are ignored while a command is pending.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;
  // command word fields
  localparam int CW_RESP   = 6;
  localparam int CW_LONG   = 7;
  localparam int CW_CRC    = 8;
  localparam int CW_WAITPD = 13;
  localparam int CW_ABORT  = 14;
  localparam int CW_START  = 31;
  // status flags
  localparam int ST_RERR = 1;
  localparam int ST_DONE = 2;
  localparam int ST_CRC  = 6;
  localparam int ST_TMO  = 8;
  localparam int ST_BUSY = 9;
  // register addresses
  localparam int A_ARG   = 0;
  localparam int A_CMD   = 1;
  localparam int A_STAT  = 2;

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_RESP} top_st_t;
  typedef enum logic [1:0] {R_IDLE, R_WAIT, R_DATA, R_FIN} rx_st_t;

  // CRC7 (x^7+x^3+1) over the low n bits of d, MSB first
  function automatic logic [6:0] crc7_of(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i < n) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_tx.sv
`timescale 1ns/1ps
module sd_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               line,
  output logic               oe,
  output logic               done
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      left   <= '0;
      active <= 1'b0;
      line   <= 1'b1;
      oe     <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh     <= frame;
        left   <= CNT_W'(FRAME_W);
        active <= 1'b1;
      end else if (active && tick) begin
        if (left != '0) begin
          line <= sh[FRAME_W-1];
          oe   <= 1'b1;
          sh   <= {sh[FRAME_W-2:0], 1'b0};
          left <= left - 1'b1;
        end else begin
          line   <= 1'b1;
          oe     <= 1'b0;
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(line) && $stable(oe)));
  // R1
  tx_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> done);
endmodule

// File: rtl/sd_cmd_rx.sv
`timescale 1ns/1ps
module sd_cmd_rx import sd_cmd_pkg::*; #(
  parameter int SHORT_W   = 48,
  parameter int STORE_W   = 128,
  parameter int TMO_TICKS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               arm,
  input  logic               long_sel,
  input  logic               line,
  output logic [STORE_W-1:0] sh,
  output logic               done,
  output logic               tmo,
  output logic               crc_bad,
  output logic               end_bad
);
  localparam int LONG_W = STORE_W + 8;
  localparam int CNT_W  = $clog2(LONG_W + 1);
  localparam int WC_W   = $clog2(TMO_TICKS + 1);

  rx_st_t           st;
  logic [CNT_W-1:0] cnt;
  logic [WC_W-1:0]  wcnt;
  logic             long_q;
  logic [CNT_W-1:0] total;
  logic [6:0]       crc_calc;

  assign total    = long_q ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
  assign crc_calc = long_q ? crc7_of(sh[STORE_W-1:8], STORE_W - 8)
                           : crc7_of(120'(sh[SHORT_W-1:8]), SHORT_W - 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      sh      <= '0;
      cnt     <= '0;
      wcnt    <= '0;
      long_q  <= 1'b0;
      done    <= 1'b0;
      tmo     <= 1'b0;
      crc_bad <= 1'b0;
      end_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      case (st)
        R_IDLE: if (arm) begin
          st     <= R_WAIT;
          wcnt   <= '0;
          sh     <= '0;
          long_q <= long_sel;
        end
        R_WAIT: if (tick) begin
          if (!line) begin
            sh  <= {sh[STORE_W-2:0], line};
            cnt <= CNT_W'(1);
            st  <= R_DATA;
          end else if (wcnt == WC_W'(TMO_TICKS - 1)) begin
            tmo <= 1'b1;
            st  <= R_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          sh  <= {sh[STORE_W-2:0], line};
          cnt <= cnt + 1'b1;
          if (cnt == total - 1'b1) st <= R_FIN;
        end
        default: begin
          done    <= 1'b1;
          crc_bad <= (crc_calc != sh[7:1]);
          end_bad <= ~sh[0];
          st      <= R_IDLE;
        end
      endcase
    end
  end

  // R9
  rx_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && tmo));
  // R9
  rx_tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |-> ($past(tick) && $past(line) && $past(st == R_WAIT)));
endmodule

// File: rtl/sd_cmd_issue.sv
`timescale 1ns/1ps
module sd_cmd_issue import sd_cmd_pkg::*; #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int TMO_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sd_tick,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  input  logic              dat_busy
);
  localparam int HDR_W   = 2 + IDX_W + DATA_W;
  localparam int FRAME_W = HDR_W + 8;
  localparam int N_RESP  = 4;
  localparam int STORE_W = N_RESP * DATA_W;

  logic [DATA_W-1:0] arg_q, cmd_q;
  logic [DATA_W-1:0] resp_q [N_RESP];
  logic              s_done, s_rerr, s_crc, s_tmo;
  top_st_t           st;

  logic               take, tx_done, rx_arm, rx_done, rx_tmo, rx_crc_bad, rx_end_bad;
  logic               we_cmd, fin_ok, resp_done, resp_tmo;
  logic [STORE_W-1:0] rx_sh;
  logic [HDR_W-1:0]   hdr;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  clr, stat_word;

  assign hdr   = {1'b0, 1'b1, cmd_q[IDX_W-1:0], arg_q};
  assign frame = {hdr, crc7_of(120'(hdr), HDR_W), 1'b1};

  assign we_cmd    = reg_we && (reg_addr == ADDR_W'(A_CMD)) && (st == T_IDLE) && !cmd_q[CW_START];
  assign take      = (st == T_IDLE) && cmd_q[CW_START] &&
                     !(cmd_q[CW_WAITPD] && !cmd_q[CW_ABORT] && dat_busy);
  assign rx_arm    = (st == T_SEND) && tx_done && cmd_q[CW_RESP];
  assign fin_ok    = (st == T_SEND) && tx_done && !cmd_q[CW_RESP];
  assign resp_done = (st == T_RESP) && rx_done;
  assign resp_tmo  = (st == T_RESP) && rx_tmo;
  assign clr       = (reg_we && reg_addr == ADDR_W'(A_STAT)) ? reg_wdata : '0;

  always_comb begin
    stat_word          = '0;
    stat_word[ST_RERR] = s_rerr;
    stat_word[ST_DONE] = s_done;
    stat_word[ST_CRC]  = s_crc;
    stat_word[ST_TMO]  = s_tmo;
    stat_word[ST_BUSY] = dat_busy;
  end

  sd_cmd_tx #(.FRAME_W(FRAME_W)) tx_i (
    .clk(clk), .rst(rst), .tick(sd_tick), .load(take), .frame(frame),
    .line(cmd_out), .oe(cmd_oe), .done(tx_done)
  );

  sd_cmd_rx #(.SHORT_W(FRAME_W), .STORE_W(STORE_W), .TMO_TICKS(TMO_TICKS)) rx_i (
    .clk(clk), .rst(rst), .tick(sd_tick), .arm(rx_arm), .long_sel(cmd_q[CW_LONG]),
    .line(cmd_in), .sh(rx_sh), .done(rx_done), .tmo(rx_tmo),
    .crc_bad(rx_crc_bad), .end_bad(rx_end_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q     <= '0;
      cmd_q     <= '0;
      st        <= T_IDLE;
      s_done    <= 1'b0;
      s_rerr    <= 1'b0;
      s_crc     <= 1'b0;
      s_tmo     <= 1'b0;
      reg_rdata <= '0;
      for (int k = 0; k < N_RESP; k++) resp_q[k] <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(A_ARG)) arg_q <= reg_wdata;
      if (we_cmd)    cmd_q <= reg_wdata;
      else if (take) cmd_q[CW_START] <= 1'b0;

      case (st)
        T_IDLE:  if (take) st <= T_SEND;
        T_SEND:  if (tx_done) st <= cmd_q[CW_RESP] ? T_RESP : T_IDLE;
        default: if (rx_done || rx_tmo) st <= T_IDLE;
      endcase

      if (resp_done) begin
        if (cmd_q[CW_LONG]) begin
          for (int k = 0; k < N_RESP; k++) resp_q[k] <= rx_sh[k*DATA_W +: DATA_W];
        end else begin
          resp_q[0] <= rx_sh[DATA_W+7:8];
        end
      end

      s_done <= fin_ok || resp_done || resp_tmo || (s_done && !clr[ST_DONE]);
      s_rerr <= (resp_done && rx_end_bad) || (s_rerr && !clr[ST_RERR]);
      s_crc  <= (resp_done && rx_crc_bad && cmd_q[CW_CRC]) || (s_crc && !clr[ST_CRC]);
      s_tmo  <= resp_tmo || (s_tmo && !clr[ST_TMO]);

      if (reg_raddr[ADDR_W-1])
        reg_rdata <= resp_q[reg_raddr[1:0]];
      else if (reg_raddr == ADDR_W'(A_ARG))  reg_rdata <= arg_q;
      else if (reg_raddr == ADDR_W'(A_CMD))  reg_rdata <= cmd_q;
      else if (reg_raddr == ADDR_W'(A_STAT)) reg_rdata <= stat_word;
      else reg_rdata <= '0;
    end
  end

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !cmd_q[CW_START]);
  // R3
  wait_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_q[CW_WAITPD] && !cmd_q[CW_ABORT]) |-> !dat_busy);
  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(s_done) |-> $past(tx_done || rx_done || rx_tmo));
  // R7
  crc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(s_crc) |-> cmd_q[CW_CRC]);
endmodule

// File: tb/sd_cmd_issue_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_issue_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        sd_tick = 1'b0;
  logic        cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  logic        dat_busy = 1'b0;

  int tests = 0;
  int fails = 0;
  int frames_seen = 0;
  logic [47:0] exp_q[$];
  logic [1:0]  tdiv = '0;
  logic        tick_seen = 1'b0;
  logic [47:0] mon_f = '0;
  int          mon_n = 0;

  always #2.5 clk = ~clk;

  sd_cmd_issue dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .sd_tick(sd_tick),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat_busy(dat_busy)
  );

  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    sd_tick <= (tdiv == 2'd3);
  end
  always @(posedge clk) tick_seen <= sd_tick;

  function automatic logic [6:0] bcrc(input logic [127:0] d, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[6] ^ d[i];
      c = c << 1;
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: collects frames from the command line and compares against the queue
  always @(negedge clk) begin
    if (!rst && tick_seen && cmd_oe) begin
      mon_f = {mon_f[46:0], cmd_out};
      mon_n++;
      if (mon_n == 48) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk("R1 unexpected frame", 128'(mon_f), 128'h0);
        else chk("R1 frame", 128'(mon_f), 128'(exp_q.pop_front()));
        frames_seen++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!sd_tick);
    @(negedge clk);
  endtask

  // driver: pushes the expected frame, then writes argument and command word
  task automatic issue(input logic [31:0] arg, input logic [31:0] cw);
    logic [39:0] h = {2'b01, cw[5:0], arg};
    exp_q.push_back({h, bcrc(128'(h), 40), 1'b1});
    wr(3'd0, arg);
    wr(3'd1, cw);
  endtask

  task automatic wait_frame(input int n);
    wait (frames_seen == n);
    wait_tick();
  endtask

  task automatic respond(input int k, input logic [135:0] f, input int len);
    repeat (k) wait_tick();
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = f[i];
      wait_tick();
    end
    cmd_in = 1'b1;
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] p,
                                             input logic [6:0] flip, input logic endb);
    logic [39:0] h = {2'b00, idx, p};
    return 136'({h, bcrc(128'(h), 40) ^ flip, endb});
  endfunction

  task automatic wait_done(output logic [31:0] v);
    for (int i = 0; i < 400; i++) begin
      rd(3'd2, v);
      if (v[2]) break;
    end
  endtask

  logic [31:0]  v;
  logic [119:0] lc;
  logic [127:0] lstore;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(3'd2, v); chk("R11 status", 128'(v), 128'h0);
    rd(3'd4, v); chk("R11 resp0", 128'(v), 128'h0);
    chk("R11 line idle", 128'({cmd_out, cmd_oe}), 128'b10);

    // R4 no response, R2/R12 readback with start cleared
    issue(32'h0000_0000, 32'hA000_1600);
    wait_frame(1);
    wait_done(v); chk("R4 done only", 128'(v), 128'h4);
    rd(3'd1, v); chk("R2 start cleared", 128'(v), 128'h2000_1600);
    rd(3'd3, v); chk("R12 unmapped", 128'(v), 128'h0);
    // R10 write-one-to-clear
    wr(3'd2, 32'hFFFF_FFFB);
    rd(3'd2, v); chk("R10 zero bits keep", 128'(v), 128'h4);
    wr(3'd2, 32'h4);
    rd(3'd2, v); chk("R10 clear", 128'(v), 128'h0);

    // R5 short response with good CRC
    issue(32'h0000_01AA, 32'h8000_0148);
    wait_frame(2);
    respond(3, short_rsp(6'd8, 32'h0000_01AA, 7'h0, 1'b1), 48);
    wait_done(v); chk("R5 status", 128'(v), 128'h4);
    rd(3'd4, v); chk("R5 resp0", 128'(v), 128'h0000_01AA);
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 bad CRC with checking on
    issue(32'h1234_0000, 32'h8000_014D);
    wait_frame(3);
    respond(0, short_rsp(6'd13, 32'hCAFE_0900, 7'h01, 1'b1), 48);
    wait_done(v); chk("R7 crc flagged", 128'(v), 128'h44);
    rd(3'd4, v); chk("R5 resp0 stored", 128'(v), 128'hCAFE_0900);
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 bad CRC with checking off
    issue(32'h1234_0000, 32'h8000_004D);
    wait_frame(4);
    respond(1, short_rsp(6'd13, 32'h0BAD_0001, 7'h40, 1'b1), 48);
    wait_done(v); chk("R7 crc unchecked", 128'(v), 128'h4);
    wr(3'd2, 32'hFFFF_FFFF);

    // R6 long response, CRC over content checked
    lc = {32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 24'hDDEEF0};
    lstore = {lc, bcrc(128'(lc), 120), 1'b1};
    issue(32'h0, 32'h8000_01C2);
    wait_frame(5);
    respond(2, {2'b00, 6'h3F, lstore}, 136);
    wait_done(v); chk("R6 R7 long status", 128'(v), 128'h4);
    rd(3'd7, v); chk("R6 word3", 128'(v), 128'(lstore[127:96]));
    rd(3'd6, v); chk("R6 word2", 128'(v), 128'(lstore[95:64]));
    rd(3'd5, v); chk("R6 word1", 128'(v), 128'(lstore[63:32]));
    rd(3'd4, v); chk("R6 word0", 128'(v), 128'(lstore[31:0]));
    wr(3'd2, 32'hFFFF_FFFF);

    // R8 end bit zero
    issue(32'h0, 32'h8000_0177);
    wait_frame(6);
    respond(0, short_rsp(6'd55, 32'h0000_0120, 7'h0, 1'b0), 48);
    wait_done(v); chk("R8 response error", 128'(v), 128'h6);
    wr(3'd2, 32'hFFFF_FFFF);

    // R9 timeout, response word untouched
    issue(32'h0, 32'h8000_0145);
    wait_frame(7);
    wait_done(v); chk("R9 timeout", 128'(v), 128'h104);
    rd(3'd4, v); chk("R9 resp kept", 128'(v), 128'h0000_0120);
    wr(3'd2, 32'hFFFF_FFFF);

    // R9 start bit on the 64th strobe is accepted
    issue(32'h0, 32'h8000_0145);
    wait_frame(8);
    respond(63, short_rsp(6'd5, 32'h00FF_8000, 7'h0, 1'b1), 48);
    wait_done(v); chk("R9 late start accepted", 128'(v), 128'h4);
    rd(3'd4, v); chk("R9 late resp0", 128'(v), 128'h00FF_8000);
    wr(3'd2, 32'hFFFF_FFFF);

    // R3 wait for previous data while busy
    dat_busy = 1'b1;
    rd(3'd2, v); chk("R3 busy mirror", 128'(v), 128'h200);
    issue(32'h0000_0007, 32'h8000_2047);
    repeat (100) @(negedge clk);
    chk("R3 held while busy", 128'(frames_seen), 128'd8);
    wr(3'd1, 32'h8000_0011);
    rd(3'd1, v); chk("R2 write ignored while pending", 128'(v), 128'h8000_2047);
    dat_busy = 1'b0;
    wait_frame(9);
    respond(0, short_rsp(6'd7, 32'h0000_0700, 7'h0, 1'b1), 48);
    wait_done(v); chk("R3 released", 128'(v), 128'h4);
    wr(3'd2, 32'hFFFF_FFFF);

    // R3 abort ignores busy
    dat_busy = 1'b1;
    issue(32'h0, 32'h8000_600C);
    wait_frame(10);
    wait_done(v); chk("R3 abort sent", 128'(v), 128'h204);
    dat_busy = 1'b0;
    chk("R1 all frames seen", 128'(exp_q.size()), 128'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule